// File: doc/BRIEF.md
# Timer Channel Clock-Source and Clear Control

This block is a single 16-bit up-counting timer channel. An 8-bit control register, written and read through a plain register port, sets three things: the source that advances the counter, the edge of that source that counts, and the event that returns the counter to zero. The source is either the system clock itself, one of six divided clocks taken from a free-running prescaler, or an external clock pin. The clear event is a compare-match or capture pulse from one of four general registers (A, B, C, D), or a clear made by a linked channel in synchronous operation.

Edge detection is built around a two-state machine that holds the level the selected source had on the previous clock. Its states are `SRC_LOW` and `SRC_HIGH`. Its transitions are *rise* (`SRC_LOW` to `SRC_HIGH`, when the selected level reads 1), *fall* (`SRC_HIGH` to `SRC_LOW`, when it reads 0), and *hold* (the level is unchanged). The edge field picks which transitions produce a count. When registers C or D are in buffer mode their events cannot clear the counter. Whenever the channel clears itself from one of A to D, it emits a one-cycle pulse that linked channels can follow.

Top module: `tmr_chan`

## Requirements
- R1: After reset the counter is 0 and the control register reads 0x00. A write with `ctl_wr` high loads `ctl_wdata` at that clock edge, and `ctl_rdata` returns the stored value from the next cycle on.
- R2: Control bits 2:0 select the source. A free-running prescaler counts every clock from 0 after reset. Code 001 uses its bit 1 (divide by 4), 010 uses bit 3 (16), 011 uses bit 5 (64), 110 uses bit 7 (256), 101 uses bit 9 (1024), and 111 uses bit 11 (4096).
- R3: Source code 100 uses `ext_clk` after two synchronising flip-flops, so the counter advances at most once per system clock.
- R4: Control bits 4:3 select the edge: 00 counts on rise, 01 on fall, 1x on both. A count occurs when the selected level differs from the level stored on the previous clock. The undivided source reads as a constant low level for this purpose.
- R5: Source code 000 advances the counter on every clock whatever the edge field holds.
- R6: Control bits 7:5 select the clear. Codes 000 and 100 never clear. Code 001 clears on `cmp_evt[0]` (A), 010 on `cmp_evt[1]` (B), 101 on `cmp_evt[2]` (C), and 110 on `cmp_evt[3]` (D). The clear takes effect at the edge where the pulse is high.
- R7: With `buf_mode_cd[0]` high, the C event cannot clear the counter. With `buf_mode_cd[1]` high, the D event cannot.
- R8: Clear codes 011 and 111 clear the counter on `sync_clr_in`, but only while `sync_en` is high.
- R9: A clear and a count in the same cycle leave the counter at 0.
- R10: The counter wraps from 0xFFFF to 0x0000. Otherwise it only steps by +1 or returns to 0.
- R11: `sync_clr_out` is high, combinationally in the same cycle, exactly when an A to D clear condition of R6/R7 holds. A clear taken through `sync_clr_in` does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| ext_clk | input | 1 | External count clock (asynchronous) |
| cmp_evt | input | 4 | Compare/capture pulses, bit 0 = A to bit 3 = D |
| buf_mode_cd | input | 2 | Buffer mode flags, bit 0 = C, bit 1 = D |
| sync_en | input | 1 | This channel takes part in synchronous clearing |
| sync_clr_in | input | 1 | Clear made by a linked channel |
| sync_clr_out | output | 1 | Pulse when this channel clears itself from A to D |
| count | output | 16 | Counter value |

## Verification
Counting and clearing can land on the same clock edge, and the clear must win. The bench provokes this directly: it selects the undivided source, which counts every cycle, and pulses the selected compare event. It expects 0 at the next sample instead of the incremented value, and expects 1 one cycle later. The same collision arises many times during the randomised phase, where divided and external sources run under random clear pulses, buffer flags and linked-channel clears. There, every cycle's counter value is compared with a reference model built from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef struct packed {
        logic [2:0] clr;
        logic [1:0] edg;
        logic [2:0] psc;
    } tmr_ctl_t;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_GA,
        CK_GB,
        CK_GC,
        CK_GD,
        CK_SYNC
    } clr_kind_e;

    typedef enum logic [1:0] {
        SRC_DIRECT,
        SRC_TAP,
        SRC_EXT
    } src_kind_e;

    typedef enum logic {
        SRC_LOW,
        SRC_HIGH
    } src_state_e;

    function automatic clr_kind_e clr_decode(input logic [2:0] code);
        clr_kind_e k;
        case (code)
            3'b001:         k = CK_GA;
            3'b010:         k = CK_GB;
            3'b101:         k = CK_GC;
            3'b110:         k = CK_GD;
            3'b011, 3'b111: k = CK_SYNC;
            default:        k = CK_NONE;
        endcase
        return k;
    endfunction

    function automatic src_kind_e src_decode(input logic [2:0] code);
        src_kind_e k;
        case (code)
            3'b000:  k = SRC_DIRECT;
            3'b100:  k = SRC_EXT;
            default: k = SRC_TAP;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int NTAP = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NTAP-1:0] wave
);
    localparam int PW = 2 * NTAP;

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PW'(1);
        end
    end

    // Tap k is the divide-by-4^(k+1) square wave.
    generate
        for (genvar k = 0; k < NTAP; k++) begin : g_tap
            assign wave[k] = div_q[2*k+1];
        end
    endgenerate

endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic level
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], ext_in};
        end
    end

    assign level = sh_q[STAGES-1];

endmodule

// File: rtl/tmr_edge_fsm.sv
module tmr_edge_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic       bypass,
    input  logic [1:0] edg,
    output logic       tick
);
    src_state_e state_q, state_d;
    logic       rise, fall;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        rise    = 1'b0;
        fall    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            SRC_LOW: begin
                if (lvl) begin
                    rise    = 1'b1;
                    state_d = SRC_HIGH;
                end
            end
            SRC_HIGH: begin
                if (!lvl) begin
                    fall    = 1'b1;
                    state_d = SRC_LOW;
                end
            end
        endcase
    end

    always_comb begin
        if (bypass) begin
            tick = 1'b1;
        end else if (edg[1]) begin
            tick = rise | fall;
        end else if (edg[0]) begin
            tick = fall;
        end else begin
            tick = rise;
        end
    end

    AST_RISE_SEES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (edg == 2'b00 && !bypass && tick) |-> lvl); // R4
    AST_FALL_SEES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (edg == 2'b01 && !bypass && tick) |-> !lvl); // R4

endmodule

// File: rtl/tmr_clr_sel.sv
module tmr_clr_sel
    import tmr_pkg::*;
#(
    parameter int NGR = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     clr_code,
    input  logic [NGR-1:0] cmp_evt,
    input  logic [1:0]     buf_mode_cd,
    input  logic           sync_en,
    input  logic           sync_in,
    output logic           own_clr,
    output logic           clr
);
    localparam int NBUF = 2;

    clr_kind_e      kind;
    logic [NGR-1:0] eff_evt;
    logic           link_clr;

    assign kind = clr_decode(clr_code);

    // Upper registers lose their event while acting as buffers.
    generate
        for (genvar g = 0; g < NGR; g++) begin : g_evt
            if (g >= NGR - NBUF) begin : g_buf
                assign eff_evt[g] = cmp_evt[g] & ~buf_mode_cd[g-(NGR-NBUF)];
            end else begin : g_plain
                assign eff_evt[g] = cmp_evt[g];
            end
        end
    endgenerate

    always_comb begin
        own_clr  = 1'b0;
        link_clr = 1'b0;
        unique case (kind)
            CK_NONE: ;
            CK_GA:   own_clr  = eff_evt[0];
            CK_GB:   own_clr  = eff_evt[1];
            CK_GC:   own_clr  = eff_evt[2];
            CK_GD:   own_clr  = eff_evt[3];
            CK_SYNC: link_clr = sync_en & sync_in;
        endcase
    end

    assign clr = own_clr | link_clr;

    AST_NONE_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_code[1:0] == 2'b00) |-> !clr); // R6
    AST_BUF_C_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_code == 3'b101 && buf_mode_cd[0]) |-> !clr); // R7
    AST_BUF_D_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_code == 3'b110 && buf_mode_cd[1]) |-> !clr); // R7
    AST_SYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_code[1:0] == 2'b11 && !sync_en) |-> !clr); // R8
    AST_LINK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_code[1:0] == 2'b11) |-> !own_clr); // R11

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NTAP       = 6,
    parameter int EXT_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rdata,
    input  logic             ext_clk,
    input  logic [3:0]       cmp_evt,
    input  logic [1:0]       buf_mode_cd,
    input  logic             sync_en,
    input  logic             sync_clr_in,
    output logic             sync_clr_out,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    tmr_ctl_t        ctl_q;
    src_kind_e       src;
    logic [NTAP-1:0] wave;
    logic            ext_lvl;
    logic            sel_lvl;
    logic            tick;
    logic            own_clr;
    logic            clr_fire;
    logic [CNT_W-1:0] cnt_q;

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= tmr_ctl_t'(ctl_wdata);
        end
    end
    assign ctl_rdata = ctl_q;

    tmr_prescaler #(.NTAP(NTAP)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .wave  (wave)
    );

    tmr_ext_sync #(.STAGES(EXT_STAGES)) u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_clk),
        .level  (ext_lvl)
    );

    // Source select: the ordering of divided taps is not monotonic in code.
    assign src = src_decode(ctl_q.psc);

    always_comb begin
        case (ctl_q.psc)
            3'b001:  sel_lvl = wave[0];
            3'b010:  sel_lvl = wave[1];
            3'b011:  sel_lvl = wave[2];
            3'b110:  sel_lvl = wave[3];
            3'b101:  sel_lvl = wave[4];
            3'b111:  sel_lvl = wave[5];
            3'b100:  sel_lvl = ext_lvl;
            default: sel_lvl = 1'b0;
        endcase
    end

    tmr_edge_fsm u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (sel_lvl),
        .bypass (src == SRC_DIRECT),
        .edg    (ctl_q.edg),
        .tick   (tick)
    );

    tmr_clr_sel #(.NGR(4)) u_clr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_code    (ctl_q.clr),
        .cmp_evt     (cmp_evt),
        .buf_mode_cd (buf_mode_cd),
        .sync_en     (sync_en),
        .sync_in     (sync_clr_in),
        .own_clr     (own_clr),
        .clr         (clr_fire)
    );

    // Counter: clear outranks count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_fire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count        = cnt_q;
    assign sync_clr_out = own_clr;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> (cnt_q == '0)); // R9
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && tick && !clr_fire) |=> (cnt_q == '0)); // R10
    AST_STEP_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)))); // R10
    AST_DIRECT_EVERY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.psc == 3'b000 && !clr_fire) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)))); // R5
    AST_PULSE_MEANS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr_out |=> (cnt_q == '0)); // R11
    AST_EXT_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.psc == 3'b100 && !clr_fire) |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)))); // R3

endmodule

// File: tb/tmr_chan_bench.sv
`timescale 1ns/1ps
module tmr_chan_bench;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        ext_clk = 1'b0;
    logic [3:0]  cmp_evt = '0;
    logic [1:0]  buf_mode_cd = '0;
    logic        sync_en = 1'b0;
    logic        sync_clr_in = 1'b0;
    logic        sync_clr_out;
    logic [15:0] count;

    int n_cmp = 0;
    int n_bad = 0;

    always #(HALF) clk = ~clk;

    tmr_chan u_tmr_chan (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .ctl_wdata    (ctl_wdata),
        .ctl_rdata    (ctl_rdata),
        .ext_clk      (ext_clk),
        .cmp_evt      (cmp_evt),
        .buf_mode_cd  (buf_mode_cd),
        .sync_en      (sync_en),
        .sync_clr_in  (sync_clr_in),
        .sync_clr_out (sync_clr_out),
        .count        (count)
    );

    // Reference model derived from the requirements
    logic [11:0] m_pre;
    logic        m_s1, m_s2, m_prev, m_now;
    logic [7:0]  m_ctl;
    logic [15:0] m_cnt;

    function automatic logic f_level(input logic [7:0] c, input logic [11:0] p, input logic s2);
        case (c[2:0])
            3'd1:    return p[1];
            3'd2:    return p[3];
            3'd3:    return p[5];
            3'd4:    return s2;
            3'd5:    return p[9];
            3'd6:    return p[7];
            3'd7:    return p[11];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic f_tick(input logic [7:0] c, input logic now, input logic prev);
        if (c[2:0] == 3'd0) return 1'b1;
        if (c[4])           return now != prev;
        if (c[3])           return prev & ~now;
        return now & ~prev;
    endfunction

    function automatic logic f_own(input logic [7:0] c, input logic [3:0] ev, input logic [1:0] bm);
        case (c[7:5])
            3'd1:    return ev[0];
            3'd2:    return ev[1];
            3'd5:    return ev[2] & ~bm[0];
            3'd6:    return ev[3] & ~bm[1];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic f_clear(input logic [7:0] c, input logic [3:0] ev, input logic [1:0] bm,
                                     input logic se, input logic si);
        return f_own(c, ev, bm) | ((c[6:5] == 2'b11) & se & si);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre <= '0; m_s1 <= 1'b0; m_s2 <= 1'b0; m_prev <= 1'b0;
            m_ctl <= '0; m_cnt <= '0;
        end else begin
            m_now  = f_level(m_ctl, m_pre, m_s2);
            m_pre  <= m_pre + 12'd1;
            m_s1   <= ext_clk;
            m_s2   <= m_s1;
            m_prev <= m_now;
            if (f_clear(m_ctl, cmp_evt, buf_mode_cd, sync_en, sync_clr_in))
                m_cnt <= '0;
            else if (f_tick(m_ctl, m_now, m_prev))
                m_cnt <= m_cnt + 16'd1;
            if (ctl_wr) m_ctl <= ctl_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag);
        @(negedge clk);
        chk(tag, 32'(count), 32'(m_cnt));
        chk("R11 sync_clr_out", 32'(sync_clr_out), 32'(f_own(m_ctl, cmp_evt, buf_mode_cd)));
        chk("R1 readback", 32'(ctl_rdata), 32'(m_ctl));
    endtask

    task automatic step(input string tag, input logic [3:0] ev, input logic si);
        cmp_evt     = ev;
        sync_clr_in = si;
        cyc(tag);
        cmp_evt     = '0;
        sync_clr_in = 1'b0;
    endtask

    task automatic wr(input string tag, input logic [7:0] v);
        ctl_wr    = 1'b1;
        ctl_wdata = v;
        cyc(tag);
        ctl_wr    = 1'b0;
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] base;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset count", 32'(count), 32'd0);
        chk("R1 reset ctl", 32'(ctl_rdata), 32'd0);
        rst_n = 1'b1;

        // R1 write/readback
        wr("R1", 8'h5A);
        chk("R1 value", 32'(ctl_rdata), 32'h5A);

        // R5 undivided source ignores edge field
        for (int e = 0; e < 4; e++) begin
            wr("R5", {3'b000, 2'(e), 3'b000});
            base = count;
            run("R5", 50);
            chk("R5 fifty clocks", 32'(count), 32'(16'(base + 16'd50)));
        end

        // R2/R4 divided sources with each edge mode on fast taps
        for (int p = 1; p < 4; p++)
            for (int e = 0; e < 4; e++) begin
                wr("R4", {3'b000, 2'(e), 3'(p)});
                run("R4", 100 << (2 * p));
            end
        wr("R2", 8'b000_00_110); run("R2", 700);
        wr("R2", 8'b000_10_101); run("R2", 2300);
        wr("R2", 8'b000_00_111); run("R2", 8500);

        // R3 external clock with random widths, including one-cycle pulses
        for (int e = 0; e < 4; e++) begin
            wr("R3", {3'b000, 2'(e), 3'b100});
            for (int i = 0; i < 300; i++) begin
                if ($urandom_range(0, 2) == 0) ext_clk = ~ext_clk;
                cyc("R3");
            end
        end

        // R6 clear sources, including disabled codes
        foreach (ev_codes[i]) ;
        for (int c = 0; c < 8; c++) begin
            wr("R6", {3'(c), 2'b00, 3'b001});
            for (int i = 0; i < 120; i++)
                step("R6", ($urandom_range(0, 7) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'b0000, 1'b0);
        end

        // R7 buffer mode suppresses C and D
        buf_mode_cd = 2'b11;
        wr("R7", 8'b101_00_000); run("R7", 5);
        base = count;
        step("R7", 4'b0100, 1'b0);
        chk("R7 C suppressed", 32'(count), 32'(16'(base + 16'd1)));
        wr("R7", 8'b110_00_000); run("R7", 5);
        step("R7", 4'b1000, 1'b0);
        chk("R7 D suppressed", 32'(count), 32'(m_cnt));
        buf_mode_cd = 2'b00;
        step("R7", 4'b1000, 1'b0);
        chk("R7 D active", 32'(count), 32'd0);

        // R8 linked clear gated by sync_en
        for (int c = 0; c < 2; c++) begin
            wr("R8", c ? 8'b111_00_000 : 8'b011_00_000);
            run("R8", 6);
            sync_en = 1'b0;
            base = count;
            step("R8", 4'b0000, 1'b1);
            chk("R8 gated off", 32'(count), 32'(16'(base + 16'd1)));
            sync_en = 1'b1;
            step("R8", 4'b1111, 1'b1);
            chk("R8 linked clear", 32'(count), 32'd0);
            chk("R11 no pulse on linked clear", 32'(sync_clr_out), 32'd0);
        end
        sync_en = 1'b0;

        // R9 clear and count in the same cycle
        wr("R9", 8'b001_00_000); run("R9", 7);
        step("R9", 4'b0001, 1'b0);
        chk("R9 clear beats count", 32'(count), 32'd0);
        cyc("R9");
        chk("R9 resumes", 32'(count), 32'd1);

        // R10 wrap
        step("R10", 4'b0001, 1'b0);
        for (int i = 0; i < 65535; i++) cyc("R10");
        chk("R10 at max", 32'(count), 32'hFFFF);
        cyc("R10");
        chk("R10 wrapped", 32'(count), 32'd0);

        // Random mix
        for (int i = 0; i < 5000; i++) begin
            if ($urandom_range(0, 31) == 0) begin
                ctl_wr = 1'b1; ctl_wdata = 8'($urandom);
            end
            if ($urandom_range(0, 63) == 0) buf_mode_cd = 2'($urandom);
            if ($urandom_range(0, 63) == 0) sync_en = ~sync_en;
            if ($urandom_range(0, 3) == 0) ext_clk = ~ext_clk;
            cmp_evt     = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0000;
            sync_clr_in = ($urandom_range(0, 15) == 0);
            cyc("random");
            ctl_wr = 1'b0; cmp_evt = '0; sync_clr_in = 1'b0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [0:0] ev_codes [1];

endmodule